// File: doc/BRIEF.md
# Character Display Register Port

This block is the host-facing register port of a four-character dot-matrix display controller. A processor drives it like a plain asynchronous peripheral: a 3-bit address, a low-active and a high-active chip enable, and low-active read and write strobes. The strobes are brought into the system clock domain through a synchroniser, and one falling edge of the write strobe commits exactly one register write. The block stores four character words and one control word. It exports them to the glyph and scanning logic that sits beside it.

The control word appears at every address whose top bit is zero. Writing it with bit 7 set erases all four character words and does not load the control settings. A second control write with bit 7 clear loads the settings. After an erase the port reports busy for a programmable number of clock cycles and ignores all host accesses. Reads capture the addressed word once, at the start of the strobe. The captured value is then driven with an output enable until the strobe rises or the device is deselected.

Top module: `dispbus_regfile`

## Requirements
- R1: An access takes effect only while `ce0N` is 0 and `ce1` is 1. A write pulse with any other enable pair leaves every register unchanged, and so does a write pulse given while the read strobe is also low. A read with any other enable pair leaves `busDataOe` at 0.
- R2: Every address with bit 2 at 0 (3'b000 to 3'b011) selects the same control register. A write through any of these addresses reads back identically from all four. Bit 7 of the control word always reads back as 0.
- R3: Addresses 3'b100, 3'b101, 3'b110 and 3'b111 select digits 0, 1, 2 and 3. Digit 0 is the rightmost. Digit n appears on `charWords[8n+7:8n]`, with ASCII in bits 6..0 and the attribute flag in bit 7. A write to one digit leaves the other digits unchanged.
- R4: The stored control bits drive the exported fields as follows: bits 1..0 go to `brightLevel`, bits 3..2 to `cursorMode`, bit 4 to `attrEnable`, bit 5 to `blinkAll` and bit 6 to `lampTest`.
- R5: A control write with bit 7 at 1 sets all 32 character bits to zero. The control register keeps its previous value, so the other bits of that write are discarded.
- R6: After an erase write commits, `busy` stays at 1 for exactly CLEAR_WAIT clock cycles. Writes given during that time are ignored, and reads given during that time leave `busDataOe` at 0.
- R7: Each low pulse on `busWrN` commits exactly one write, using the data present when the synchronised falling edge is seen. Later changes on `busDataIn` while the strobe stays low have no effect.
- R8: A selected read drives `busDataOe` to 1 and presents the addressed word on `busDataOut`. That word stays stable while the read is held. `busDataOe` returns to 0 after the read strobe rises.
- R9: With INIT_ZERO set, reset clears all character words and the control word, and it sets `busy` and `busDataOe` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| ce0N | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| busAddr | input | 3 | Register address |
| busRdN | input | 1 | Read strobe, active low |
| busWrN | input | 1 | Write strobe, active low |
| busDataIn | input | 8 | Data from the host bus |
| busDataOut | output | 8 | Read data toward the host bus |
| busDataOe | output | 1 | Tristate enable for busDataOut |
| busy | output | 1 | Erase settle window in progress |
| charWords | output | 32 | Four character words, digit 0 in the low byte |
| brightLevel | output | 2 | Brightness select |
| cursorMode | output | 2 | Attribute style select |
| attrEnable | output | 1 | Attribute enable for flagged digits |
| blinkAll | output | 1 | Whole-display blink |
| lampTest | output | 1 | All dots at half brightness |

## Verification
A corrupted character or control register shows up on the exported fields in the cycle after the faulty commit. It is also seen on the next readback, which samples the word at the start of the read. A fault in the hold-off counter changes the number of cycles that `busy` is high. It can also let a write through during the window, and that write would show as a non-zero digit after the window ends. A fault in the edge detector or the mirrored decode causes a second commit while the strobe is held low, or a control value that differs between mirror addresses. Either is visible on the very next read.

// File: rtl/dispbus_pkg.sv
package dispbus_pkg;

  localparam int NUM_DIGITS = 4;
  localparam int WORD_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int CTRL_W     = WORD_W - 1;
  localparam int SEL_W      = $clog2(NUM_DIGITS);

  // control field positions decoded by the display logic
  localparam int BRIGHT_LSB = 0;
  localparam int CURSOR_LSB = 2;
  localparam int ATTR_BIT   = 4;
  localparam int BLINK_BIT  = 5;
  localparam int LAMP_BIT   = 6;

  typedef struct packed {
    logic             wrChar;
    logic             wrCtrl;
    logic             clrChars;
    logic             capRead;
    logic             ctrlSel;
    logic [SEL_W-1:0] digitSel;
  } busStrobe_t;

endpackage

// File: rtl/dispbus_ctrl.sv
module dispbus_ctrl
  import dispbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CLEAR_WAIT  = 125000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ce0N,
  input  logic              ce1,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRdN,
  input  logic              busWrN,
  input  logic              eraseBit,
  output busStrobe_t        strobe,
  output logic              busy,
  output logic              readActive
);

  localparam int CNT_W = $clog2(CLEAR_WAIT + 1);

  logic [SYNC_STAGES-1:0] wrSync;
  logic [SYNC_STAGES-1:0] rdSync;
  logic                   wrLast;
  logic                   rdLast;
  logic                   wrSynced;
  logic                   rdSynced;
  logic                   wrFall;
  logic                   rdFall;
  logic                   devSel;
  logic                   writeGo;
  logic                   readGo;
  logic [CNT_W-1:0]       busyCnt;

  // strobe synchronisers, idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSync <= '1;
      rdSync <= '1;
      wrLast <= 1'b1;
      rdLast <= 1'b1;
    end else begin
      wrSync <= {wrSync[SYNC_STAGES-2:0], busWrN};
      rdSync <= {rdSync[SYNC_STAGES-2:0], busRdN};
      wrLast <= wrSync[SYNC_STAGES-1];
      rdLast <= rdSync[SYNC_STAGES-1];
    end
  end

  assign wrSynced = wrSync[SYNC_STAGES-1];
  assign rdSynced = rdSync[SYNC_STAGES-1];
  assign wrFall   = wrLast & ~wrSynced;
  assign rdFall   = rdLast & ~rdSynced;
  assign devSel   = ~ce0N & ce1;

  assign writeGo = wrFall & devSel & rdSynced & ~busy;
  assign readGo  = rdFall & devSel & ~busy;

  always_comb begin
    strobe          = '0;
    strobe.wrChar   = writeGo & busAddr[ADDR_W-1];
    strobe.wrCtrl   = writeGo & ~busAddr[ADDR_W-1] & ~eraseBit;
    strobe.clrChars = writeGo & ~busAddr[ADDR_W-1] & eraseBit;
    strobe.capRead  = readGo;
    strobe.ctrlSel  = ~busAddr[ADDR_W-1];
    strobe.digitSel = busAddr[SEL_W-1:0];
  end

  // erase settle window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (strobe.clrChars) begin
      busyCnt <= CNT_W'(CLEAR_WAIT);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = (busyCnt != '0);

  // read window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readActive <= 1'b0;
    end else if (readGo) begin
      readActive <= 1'b1;
    end else if (rdSynced || !devSel) begin
      readActive <= 1'b0;
    end
  end

endmodule

// File: rtl/dispbus_data.sv
module dispbus_data
  import dispbus_pkg::*;
#(
  parameter bit INIT_ZERO = 1'b1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  busStrobe_t                   strobe,
  input  logic [WORD_W-1:0]            busDataIn,
  output logic [WORD_W-1:0]            rdData,
  output logic [NUM_DIGITS*WORD_W-1:0] charWords,
  output logic [CTRL_W-1:0]            ctrlWord
);

  logic [NUM_DIGITS-1:0][WORD_W-1:0] charMem;
  logic [NUM_DIGITS-1:0][WORD_W-1:0] charNext;
  logic [CTRL_W-1:0]                 ctrlReg;
  logic [CTRL_W-1:0]                 ctrlNext;

  always_comb begin
    for (int d = 0; d < NUM_DIGITS; d++) begin
      if (strobe.clrChars) begin
        charNext[d] = '0;
      end else if (strobe.wrChar && (strobe.digitSel == SEL_W'(d))) begin
        charNext[d] = busDataIn;
      end else begin
        charNext[d] = charMem[d];
      end
    end
    ctrlNext = strobe.wrCtrl ? busDataIn[CTRL_W-1:0] : ctrlReg;
  end

  generate
    if (INIT_ZERO) begin : g_initZero
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          charMem <= '0;
          ctrlReg <= '0;
        end else begin
          charMem <= charNext;
          ctrlReg <= ctrlNext;
        end
      end
    end else begin : g_noInit
      always_ff @(posedge clk) begin
        charMem <= charNext;
        ctrlReg <= ctrlNext;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.capRead) begin
      rdData <= strobe.ctrlSel ? {1'b0, ctrlReg} : charMem[strobe.digitSel];
    end
  end

  generate
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_export
      assign charWords[g*WORD_W +: WORD_W] = charMem[g];
    end
  endgenerate

  assign ctrlWord = ctrlReg;

endmodule

// File: rtl/dispbus_regfile.sv
module dispbus_regfile
  import dispbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CLEAR_WAIT  = 125000,
  parameter bit INIT_ZERO   = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ce0N,
  input  logic        ce1,
  input  logic [2:0]  busAddr,
  input  logic        busRdN,
  input  logic        busWrN,
  input  logic [7:0]  busDataIn,
  output logic [7:0]  busDataOut,
  output logic        busDataOe,
  output logic        busy,
  output logic [31:0] charWords,
  output logic [1:0]  brightLevel,
  output logic [1:0]  cursorMode,
  output logic        attrEnable,
  output logic        blinkAll,
  output logic        lampTest
);

  busStrobe_t        strobe;
  logic [CTRL_W-1:0] ctrlWord;

  dispbus_ctrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .CLEAR_WAIT  (CLEAR_WAIT)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ce0N       (ce0N),
    .ce1        (ce1),
    .busAddr    (busAddr),
    .busRdN     (busRdN),
    .busWrN     (busWrN),
    .eraseBit   (busDataIn[WORD_W-1]),
    .strobe     (strobe),
    .busy       (busy),
    .readActive (busDataOe)
  );

  dispbus_data #(
    .INIT_ZERO (INIT_ZERO)
  ) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busDataIn (busDataIn),
    .rdData    (busDataOut),
    .charWords (charWords),
    .ctrlWord  (ctrlWord)
  );

  assign brightLevel = ctrlWord[BRIGHT_LSB +: 2];
  assign cursorMode  = ctrlWord[CURSOR_LSB +: 2];
  assign attrEnable  = ctrlWord[ATTR_BIT];
  assign blinkAll    = ctrlWord[BLINK_BIT];
  assign lampTest    = ctrlWord[LAMP_BIT];

endmodule

// File: rtl/dispbus_regfile_chk.sv
module dispbus_regfile_chk #(
  parameter int CLEAR_WAIT = 125000
) (
  input logic        clk,
  input logic        rstN,
  input logic        ce0N,
  input logic        ce1,
  input logic [7:0]  busDataOut,
  input logic        busDataOe,
  input logic        busy,
  input logic [31:0] charWords,
  input logic [1:0]  brightLevel,
  input logic [1:0]  cursorMode,
  input logic        attrEnable,
  input logic        blinkAll,
  input logic        lampTest
);

  localparam int RUN_W = $clog2(CLEAR_WAIT + 1) + 1;

  logic [RUN_W-1:0] busyRun;
  logic [6:0]       ctrlView;

  assign ctrlView = {lampTest, blinkAll, attrEnable, cursorMode, brightLevel};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyRun <= '0;
    end else if (busy) begin
      busyRun <= busyRun + 1'b1;
    end else begin
      busyRun <= '0;
    end
  end

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(CLEAR_WAIT));

  p_no_read_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !busDataOe);

  p_chars_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(charWords));

  p_ctrl_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(ctrlView));

  p_erase_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (charWords == 32'h0));

  p_oe_selected_r1: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> $past(!ce0N && ce1));

  p_read_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busDataOe && $past(busDataOe)) |-> $stable(busDataOut));

endmodule

bind dispbus_regfile dispbus_regfile_chk #(.CLEAR_WAIT(CLEAR_WAIT)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ce0N        (ce0N),
  .ce1         (ce1),
  .busDataOut  (busDataOut),
  .busDataOe   (busDataOe),
  .busy        (busy),
  .charWords   (charWords),
  .brightLevel (brightLevel),
  .cursorMode  (cursorMode),
  .attrEnable  (attrEnable),
  .blinkAll    (blinkAll),
  .lampTest    (lampTest)
);

// File: tb/test_dispbus_regfile.sv
`timescale 1ns/1ps
module test_dispbus_regfile;

  localparam int WAIT_CYC = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ce0N = 1'b1;
  logic        ce1 = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busRdN = 1'b1;
  logic        busWrN = 1'b1;
  logic [7:0]  busDataIn = '0;
  logic [7:0]  busDataOut;
  logic        busDataOe;
  logic        busy;
  logic [31:0] charWords;
  logic [1:0]  brightLevel;
  logic [1:0]  cursorMode;
  logic        attrEnable;
  logic        blinkAll;
  logic        lampTest;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  logic [7:0] model [4];
  logic [6:0] ctrlModel;

  always #4 clk = ~clk;

  dispbus_regfile #(
    .SYNC_STAGES (2),
    .CLEAR_WAIT  (WAIT_CYC),
    .INIT_ZERO   (1'b1)
  ) i_dispbus_regfile (
    .clk (clk), .rstN (rstN), .ce0N (ce0N), .ce1 (ce1),
    .busAddr (busAddr), .busRdN (busRdN), .busWrN (busWrN),
    .busDataIn (busDataIn), .busDataOut (busDataOut), .busDataOe (busDataOe),
    .busy (busy), .charWords (charWords), .brightLevel (brightLevel),
    .cursorMode (cursorMode), .attrEnable (attrEnable), .blinkAll (blinkAll),
    .lampTest (lampTest)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] v,
                          input logic c0, input logic c1);
    @(negedge clk);
    busAddr = a; busDataIn = v; ce0N = c0; ce1 = c1;
    busWrN = 1'b0;
    idle(5);
    busWrN = 1'b1;
    idle(5);
    ce0N = 1'b1; ce1 = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] v,
                         output logic oeSeen);
    @(negedge clk);
    busAddr = a; ce0N = 1'b0; ce1 = 1'b1;
    busRdN = 1'b0;
    idle(5);
    v = busDataOut;
    oeSeen = busDataOe;
    busRdN = 1'b1;
    idle(5);
    check(busDataOe == 1'b0, "R8 release after read", {31'b0, busDataOe}, 32'h0);
    ce0N = 1'b1; ce1 = 1'b0;
  endtask

  task automatic checkOutputs(input string req);
    logic [31:0] expWords;
    expWords = {model[3], model[2], model[1], model[0]};
    check(charWords == expWords, req, charWords, expWords);
    check({lampTest, blinkAll, attrEnable, cursorMode, brightLevel} == ctrlModel,
          {req, " R4 fields"},
          {25'b0, lampTest, blinkAll, attrEnable, cursorMode, brightLevel},
          {25'b0, ctrlModel});
  endtask

  task automatic readExpect(input logic [2:0] a, input logic [7:0] exp,
                            input string req);
    logic [7:0] v;
    logic       oe;
    busRead(a, v, oe);
    check(oe == 1'b1, {req, " R8 oe"}, {31'b0, oe}, 32'h1);
    check(v == exp, req, {24'b0, v}, {24'b0, exp});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL all watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic       oe;
    int         busyCount;

    for (int d = 0; d < 4; d++) model[d] = 8'h00;
    ctrlModel = 7'h00;

    idle(5);
    rstN = 1'b1;
    idle(3);

    // R9 reset state
    check(busy == 1'b0, "R9 busy after reset", {31'b0, busy}, 32'h0);
    check(busDataOe == 1'b0, "R9 oe after reset", {31'b0, busDataOe}, 32'h0);
    checkOutputs("R9 storage after reset");

    // R3 digit sweep
    for (int d = 0; d < 4; d++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] val;
        val = 8'((d * 61 + k * 37 + 5) & 255);
        if (k == 3) val = val | 8'h80;
        busWrite(3'(4 + d), val, 1'b0, 1'b1);
        model[d] = val;
        checkOutputs("R3 digit write");
        for (int r = 0; r < 4; r++) readExpect(3'(4 + r), model[r], "R3 digit readback");
      end
    end

    // R2 / R4 control mirror sweep
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 3; k++) begin
        logic [6:0] cv;
        cv = 7'((m * 29 + k * 43 + 11) & 127);
        busWrite(3'(m), {1'b0, cv}, 1'b0, 1'b1);
        ctrlModel = cv;
        checkOutputs("R2 control write");
        for (int r = 0; r < 4; r++) readExpect(3'(r), {1'b0, ctrlModel}, "R2 mirror readback");
      end
    end

    // R1 deselected writes and write during read
    busWrite(3'b101, 8'h5A, 1'b1, 1'b1);
    checkOutputs("R1 ce0N high write");
    busWrite(3'b101, 8'h5A, 1'b0, 1'b0);
    checkOutputs("R1 ce1 low write");
    busWrite(3'b101, 8'h5A, 1'b1, 1'b0);
    checkOutputs("R1 both disabled write");
    busWrite(3'b010, 8'h7F, 1'b1, 1'b1);
    checkOutputs("R1 deselected control write");

    @(negedge clk);
    busAddr = 3'b110; busDataIn = 8'h33; ce0N = 1'b0; ce1 = 1'b1;
    busRdN = 1'b0; busWrN = 1'b0;
    idle(5);
    busWrN = 1'b1; busRdN = 1'b1;
    idle(5);
    ce0N = 1'b1; ce1 = 1'b0;
    checkOutputs("R1 write with read low");

    @(negedge clk);
    busAddr = 3'b100; ce0N = 1'b1; ce1 = 1'b1; busRdN = 1'b0;
    idle(5);
    check(busDataOe == 1'b0, "R1 deselected read oe", {31'b0, busDataOe}, 32'h0);
    busRdN = 1'b1; ce1 = 1'b0;
    idle(5);

    // R7 one write per pulse
    @(negedge clk);
    busAddr = 3'b111; busDataIn = 8'h41; ce0N = 1'b0; ce1 = 1'b1;
    busWrN = 1'b0;
    idle(5);
    busDataIn = 8'hC2;
    idle(5);
    busWrN = 1'b1;
    idle(5);
    ce0N = 1'b1; ce1 = 1'b0;
    model[3] = 8'h41;
    checkOutputs("R7 held strobe");
    readExpect(3'b111, 8'h41, "R7 held strobe readback");

    // R5 / R6 erase with discarded low bits and busy length
    busWrite(3'b000, 8'h17, 1'b0, 1'b1);
    ctrlModel = 7'h17;
    @(negedge clk);
    busAddr = 3'b010; busDataIn = 8'h85; ce0N = 1'b0; ce1 = 1'b1;
    busWrN = 1'b0;
    busyCount = 0;
    for (int c = 0; c < WAIT_CYC + 20; c++) begin
      @(negedge clk);
      if (c == 5) busWrN = 1'b1;
      if (busy) busyCount++;
    end
    ce0N = 1'b1; ce1 = 1'b0;
    for (int d = 0; d < 4; d++) model[d] = 8'h00;
    check(busyCount == WAIT_CYC, "R6 busy length", 32'(busyCount), 32'(WAIT_CYC));
    checkOutputs("R5 erase result");
    readExpect(3'b001, 8'h17, "R5 control kept after erase");
    readExpect(3'b101, 8'h00, "R5 digit erased");

    // R6 accesses ignored during busy
    busWrite(3'b110, 8'h4D, 1'b0, 1'b1);
    busWrite(3'b000, 8'h80, 1'b0, 1'b1);
    check(busy == 1'b1, "R6 busy after erase", {31'b0, busy}, 32'h1);
    busWrite(3'b110, 8'h4D, 1'b0, 1'b1);
    busRead(3'b110, v, oe);
    check(oe == 1'b0, "R6 read during busy", {31'b0, oe}, 32'h0);
    idle(WAIT_CYC + 5);
    check(busy == 1'b0, "R6 busy ended", {31'b0, busy}, 32'h0);
    checkOutputs("R6 write during busy ignored");
    readExpect(3'b110, 8'h00, "R6 write during busy ignored readback");

    // R2 second control write after erase
    busWrite(3'b011, 8'h3E, 1'b0, 1'b1);
    ctrlModel = 7'h3E;
    checkOutputs("R2 post-erase control");
    readExpect(3'b000, 8'h3E, "R2 post-erase readback");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule